// File: doc/BRIEF.md
# Scan-Programmed Logic Cell Array

This block is a small field-programmable array of 24 logic cells, laid out as 4 rows of 6 cells. Each cell holds a 6-bit configuration word. The word sets a 2-input lookup table, chooses whether the cell drives its table result or a stored state bit, and chooses which of its two inputs enables that state bit.

All configuration words sit on one serial shift chain, 144 bits long, that runs from `sdi` to `sdo`. With `prog` high the chain shifts one bit per clock. This path both loads the array and reads the loaded words back out for test. With `prog` low the configuration holds and the cells compute.

Cells in a row are cascaded. Each cell after the first takes the previous cell's output as its first input, so wide functions such as a multi-bit XOR can be built along a row. Ten primary inputs feed the cells, and ten outputs are tapped from the ends of the rows.

Top module: `fpla_array`

## Requirements
- R1: While `rst_n` is low, every configuration bit and every cell state bit is cleared. As a result, `dout` and `sdo` are both 0.
- R2: With `prog` high, each clock shifts `sdi` into the chain, so 144 shifts fill the array and the first bit shifted in lands in cell 23 (row 3, column 5). Cell k (k = row*6 + col) takes 6 consecutive bits. The first of its bits shifted in is word bit 5, the enable source (0 = in1, 1 = in2). Word bit 4 is the output select (0 = table, 1 = state bit). Bits 3..0 are the table, where the entry for address a = {in1,in2} is word bit 3-a.
- R3: With `prog` low, the configuration does not change.
- R4: `sdo` shows the chain's last bit. A further 144 shifts with `prog` high return the configuration bits in the order they were loaded.
- R5: A cell whose output select is 0 drives, combinationally, the table entry addressed by {in1,in2}.
- R6: With `prog` low, a cell's state bit captures its table result at the clock edge when its selected enable input is 1, and otherwise holds. With `prog` high, every state bit holds. A cell whose output select is 1 drives its state bit.
- R7: Cell (r,c) with c > 0 takes in1 from cell (r,c-1). Cell (r,0) takes in1 from `din[(r+6) mod 10]`. Every cell (r,c) takes in2 from `din[(r+c) mod 10]`.
- R8: `dout[k]` is the output of the cell in row k mod 4, column 5 - (k div 4).
- R9: Loading the XOR word 000110 into cells (0,0)..(0,3) and the pass-in1 word 000011 into cells (0,4) and (0,5) gives `dout[0]` = din6 ^ din0 ^ din1 ^ din2 ^ din3.
- R10: With every configuration bit at 0, every `dout` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, sampled at the clock edge |
| prog | input | 1 | 1 = shift the configuration chain, 0 = normal operation |
| sdi | input | 1 | Serial data into the first chain bit |
| din | input | 10 | Primary data inputs |
| sdo | output | 1 | Serial data from the last chain bit |
| dout | output | 10 | Primary data outputs |

## Verification
A wrong configuration bit shows up in two places. It appears at `dout` as a wrong function of `din`, in the same cycle the inputs are applied, whenever that cell lies on a path to a tapped output. It also appears at `sdo` during the following readback, at the exact shift position of that bit. A wrong state bit shows up at `dout` one cycle after the capturing edge, and only through cells whose output select is set. The bench runs a cycle-accurate arithmetic model of all 24 cells over randomized words and input sweeps, so either kind of error is caught within one cycle of becoming visible.

// File: rtl/fpla_pkg.sv
package fpla_pkg;

    localparam int CFG_W = 6;

    // bit 5 first shifted in: enable source; bit 4: output select; bits 3..0: table
    typedef struct packed {
        logic       en_sel;
        logic       out_sel;
        logic [3:0] tbl;
    } cell_cfg_t;

    typedef struct packed {
        cell_cfg_t cfg;
        logic      st;
    } cell_reg_t;

endpackage

// File: rtl/fpla_cell.sv
module fpla_cell
    import fpla_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog,
    input  logic             scan_i,
    input  logic             in1,
    input  logic             in2,
    output logic             scan_o,
    output logic             y,
    output logic [CFG_W-1:0] cfg_o,
    output logic             st_o
);

    cell_reg_t  r_d, r_q;
    logic [1:0] addr_inv;
    logic       lut_v;
    logic       en_v;

    always_comb begin
        r_d      = r_q;
        addr_inv = ~{in1, in2};
        lut_v    = r_q.cfg.tbl[addr_inv];
        en_v     = r_q.cfg.en_sel ? in2 : in1;
        if (prog) begin
            r_d.cfg = cell_cfg_t'({r_q.cfg[CFG_W-2:0], scan_i});
        end else if (en_v) begin
            r_d.st = lut_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign y      = r_q.cfg.out_sel ? r_q.st : lut_v;
    assign scan_o = r_q.cfg[CFG_W-1];
    assign cfg_o  = r_q.cfg;
    assign st_o   = r_q.st;

endmodule

// File: rtl/fpla_row.sv
module fpla_row
    import fpla_pkg::*;
#(
    parameter int COLS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog,
    input  logic                  scan_i,
    input  logic                  in1_first,
    input  logic [COLS-1:0]       in2_v,
    output logic                  scan_o,
    output logic [COLS-1:0]       y_v,
    output logic [COLS*CFG_W-1:0] cfg_o,
    output logic [COLS-1:0]       st_o
);

    for (genvar c = 0; c < COLS; c++) begin : gen_col
        logic y_c;
        logic so_c;
        logic a_c;
        logic si_c;

        if (c == 0) begin : gen_head
            assign a_c  = in1_first;
            assign si_c = scan_i;
        end else begin : gen_tail
            assign a_c  = gen_col[c-1].y_c;
            assign si_c = gen_col[c-1].so_c;
        end

        fpla_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .prog   (prog),
            .scan_i (si_c),
            .in1    (a_c),
            .in2    (in2_v[c]),
            .scan_o (so_c),
            .y      (y_c),
            .cfg_o  (cfg_o[c*CFG_W +: CFG_W]),
            .st_o   (st_o[c])
        );

        assign y_v[c] = y_c;
    end

    assign scan_o = gen_col[COLS-1].so_c;

endmodule

// File: rtl/fpla_array.sv
module fpla_array
    import fpla_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 6,
    parameter int NIN  = 10,
    parameter int NOUT = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog,
    input  logic            sdi,
    input  logic [NIN-1:0]  din,
    output logic            sdo,
    output logic [NOUT-1:0] dout
);

    localparam int NCELL     = ROWS * COLS;
    localparam int ROW_BITS  = COLS * CFG_W;
    localparam int CHAIN_LEN = NCELL * CFG_W;

    logic [CHAIN_LEN-1:0] cfg_flat;
    logic [NCELL-1:0]     st_flat;
    logic [NCELL-1:0]     y_flat;

    for (genvar r = 0; r < ROWS; r++) begin : gen_row
        logic            so_r;
        logic            si_r;
        logic [COLS-1:0] in2_r;

        if (r == 0) begin : gen_first
            assign si_r = sdi;
        end else begin : gen_next
            assign si_r = gen_row[r-1].so_r;
        end

        for (genvar c = 0; c < COLS; c++) begin : gen_in2
            assign in2_r[c] = din[(r + c) % NIN];
        end

        fpla_row #(.COLS(COLS)) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog),
            .scan_i    (si_r),
            .in1_first (din[(r + COLS) % NIN]),
            .in2_v     (in2_r),
            .scan_o    (so_r),
            .y_v       (y_flat[r*COLS +: COLS]),
            .cfg_o     (cfg_flat[r*ROW_BITS +: ROW_BITS]),
            .st_o      (st_flat[r*COLS +: COLS])
        );
    end

    assign sdo = gen_row[ROWS-1].so_r;

    for (genvar k = 0; k < NOUT; k++) begin : gen_tap
        localparam int TR = k % ROWS;
        localparam int TC = COLS - 1 - (k / ROWS);
        assign dout[k] = y_flat[TR*COLS + TC];
    end

endmodule

// File: rtl/fpla_array_chk.sv
module fpla_array_chk #(
    parameter int CHAIN_LEN = 144,
    parameter int NCELL     = 24,
    parameter int NOUT      = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 prog,
    input logic                 sdi,
    input logic                 sdo,
    input logic [NOUT-1:0]      dout,
    input logic [CHAIN_LEN-1:0] cfg_flat,
    input logic [NCELL-1:0]     st_flat
);

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (cfg_flat == {$past(cfg_flat[CHAIN_LEN-2:0]), $past(sdi)}));

    p_hold_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !prog |=> $stable(cfg_flat));

    p_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (sdo == $past(cfg_flat[CHAIN_LEN-2])));

    p_state_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> $stable(st_flat));

    p_zero_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat == '0) |-> (dout == '0));

endmodule

bind fpla_array fpla_array_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .NCELL     (NCELL),
    .NOUT      (NOUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog     (prog),
    .sdi      (sdi),
    .sdo      (sdo),
    .dout     (dout),
    .cfg_flat (cfg_flat),
    .st_flat  (st_flat)
);

// File: tb/fpla_array_tb.sv
module fpla_array_tb_top;

    localparam int ROWS  = 4;
    localparam int COLS  = 6;
    localparam int NIN   = 10;
    localparam int NOUT  = 10;
    localparam int NCELL = ROWS * COLS;
    localparam int CLEN  = NCELL * 6;
    localparam time TCLK = 8ns;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            prog;
    logic            sdi;
    logic [NIN-1:0]  din;
    logic            sdo;
    logic [NOUT-1:0] dout;

    int checks = 0;
    int errors = 0;

    logic [5:0]       words [NCELL];
    logic [NCELL-1:0] st;

    always #(TCLK/2) clk = ~clk;

    fpla_array #(.ROWS(ROWS), .COLS(COLS), .NIN(NIN), .NOUT(NOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog(prog), .sdi(sdi),
        .din(din), .sdo(sdo), .dout(dout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic lutf(input logic [5:0] w, input logic a, input logic b);
        int idx;
        idx = 3 - ((a ? 2 : 0) + (b ? 1 : 0));
        return w[idx];
    endfunction

    task automatic model_eval(input logic [NIN-1:0] d, output logic [NOUT-1:0] e,
                              output logic [NCELL-1:0] stn);
        logic [NCELL-1:0] yv;
        yv  = '0;
        stn = st;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int   k;
                logic i1, i2, l, en;
                k  = r * COLS + c;
                i1 = (c == 0) ? d[(r + COLS) % NIN] : yv[k-1];
                i2 = d[(r + c) % NIN];
                l  = lutf(words[k], i1, i2);
                yv[k]  = words[k][4] ? st[k] : l;
                en     = words[k][5] ? i2 : i1;
                stn[k] = en ? l : st[k];
            end
        end
        for (int k = 0; k < NOUT; k++)
            e[k] = yv[(k % ROWS) * COLS + COLS - 1 - k / ROWS];
    endtask

    // one normal-mode cycle; exp0 >= 0 adds an explicit check of dout[0]
    task automatic run_cycle(input logic [NIN-1:0] d, input string tag, input int exp0);
        logic [NOUT-1:0]  e;
        logic [NCELL-1:0] stn;
        @(negedge clk);
        prog = 1'b0;
        din  = d;
        #1;
        model_eval(d, e, stn);
        chk(tag, 32'(dout), 32'(e));
        if (exp0 >= 0) chk({tag, " explicit"}, 32'(dout[0]), 32'(exp0));
        @(posedge clk);
        st = stn;
    endtask

    task automatic load_words();
        for (int k = NCELL - 1; k >= 0; k--) begin
            for (int b = 5; b >= 0; b--) begin
                @(negedge clk);
                prog = 1'b1;
                sdi  = words[k][b];
                @(posedge clk);
            end
        end
    endtask

    // shift out the whole chain with zero fill; words become all zero
    task automatic readback(input string tag);
        int i;
        i = 0;
        for (int k = NCELL - 1; k >= 0; k--) begin
            for (int b = 5; b >= 0; b--) begin
                @(negedge clk);
                prog = 1'b1;
                sdi  = 1'b0;
                #1;
                if (i == 0 || i == CLEN - 1 || sdo !== words[k][b])
                    chk(tag, 32'(sdo), 32'(words[k][b]));
                i++;
                @(posedge clk);
            end
        end
        for (int k = 0; k < NCELL; k++) words[k] = '0;
    endtask

    initial begin
        #(TCLK * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        prog  = 1'b0;
        sdi   = 1'b0;
        din   = '0;
        st    = '0;
        for (int k = 0; k < NCELL; k++) words[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        din = '1;
        #1;
        chk("R1 reset dout", 32'(dout), 32'h0);
        chk("R1 reset sdo", 32'(sdo), 32'h0);
        rst_n = 1'b1;

        // R10 zero config under input sweep
        for (int v = 0; v < 64; v++) run_cycle(NIN'(v * 37), "R10 zero config", 0);

        // R5 R7 R8: every cell XOR, exhaustive input sweep against model
        for (int k = 0; k < NCELL; k++) words[k] = 6'b000110;
        load_words();
        for (int v = 0; v < (1 << NIN); v++) run_cycle(NIN'(v), "R5 R7 R8 xor array", -1);

        // R9: 5-bit XOR along row 0
        for (int k = 0; k < NCELL; k++) words[k] = '0;
        for (int c = 0; c < 4; c++) words[c] = 6'b000110;
        words[4] = 6'b000011;
        words[5] = 6'b000011;
        load_words();
        for (int v = 0; v < (1 << NIN); v++) begin
            logic [NIN-1:0] d;
            d = NIN'(v);
            run_cycle(d, "R9 xor5", int'(d[6] ^ d[0] ^ d[1] ^ d[2] ^ d[3]));
        end

        // R6: row-0 head as enabled D flip-flop (data din6, enable din0)
        words[0] = 6'b110011;
        for (int c = 1; c < 6; c++) words[c] = 6'b000011;
        load_words();
        run_cycle(10'b0001000001, "R6 capture", -1);
        run_cycle(10'b0000000000, "R6 held one", 1);
        run_cycle(10'b0000000001, "R6 pre-capture", 1);
        run_cycle(10'b0000000000, "R6 captured zero", 0);
        run_cycle(10'b0001000000, "R6 disabled", 0);

        // R2 R3 R4 R6: random words, random inputs, then readback
        for (int round = 0; round < 6; round++) begin
            for (int k = 0; k < NCELL; k++) words[k] = 6'($urandom());
            load_words();
            for (int n = 0; n < 300; n++) run_cycle(NIN'($urandom()), "R2 R5 R6 random", -1);
            readback("R4 R3 readback");
            for (int n = 0; n < 8; n++) run_cycle(NIN'($urandom()), "R10 R6 after readback", 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule